// File: doc/BRIEF.md
# Bayer Frame Statistics Accumulator

This block watches a raw colour-filter-array pixel stream and, over one frame, collects the numbers that a combined gray-world / brightest-white balance fit needs. The mosaic is RGGB. Each pixel goes to exactly one colour channel, chosen by the parity of its row and column. For red and blue sites the block keeps the running sum of the pixel value, the running sum of its square, the largest value and the largest squared value. Green sites take the same path minus the squaring, so green keeps only a sum and a maximum.

A frame begins with a one-cycle `frame_start` pulse. Pixels then arrive in raster order and are qualified by `pix_valid`, which may drop for any number of cycles. When the last pixel of a `COLS` x `ROWS` frame has been taken, `stats_done` pulses for one cycle. All results are final in that cycle and stay frozen until the next `frame_start`. Solving the fit and correcting pixels are done elsewhere.

Top module: `bayer_stats`

## Requirements
- R1: After reset every sum and maximum output reads zero and `stats_done` is low.
- R2: Pixel k of a frame (counting only accepted pixels from 0) sits at row k / COLS and column k mod COLS. Even row with even column is red, odd row with odd column is blue, and the other two cases are green.
- R3: `red_sum` and `blu_sum` are the frame sums of the pixel value on their sites. `red_sqsum` and `blu_sqsum` are the frame sums of the squared pixel value on those sites.
- R4: `red_max` and `blu_max` are the largest pixel values on their sites. `red_sqmax` and `blu_sqmax` equal the largest squared pixel value on those sites.
- R5: `grn_sum` and `grn_max` are the sum and the maximum of all green-site pixel values.
- R6: `frame_start` clears every sum and maximum and returns the position to row 0, column 0, even in the middle of a frame. A pixel marked valid in the same cycle as `frame_start` is dropped.
- R7: `stats_done` is high for exactly the one cycle after the edge that takes the COLS*ROWS-th pixel, and the outputs are final in that cycle.
- R8: After the last pixel, further valid pixels are ignored and all outputs hold until the next `frame_start`.
- R9: Cycles with `pix_valid` low change no output and do not advance the pixel position.
- R10: Sums are wide enough that a frame of all full-scale pixels does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse opening a new frame |
| pix_valid | input | 1 | Qualifies pix_data |
| pix_data | input | PIX_W | Unsigned raw pixel value |
| stats_done | output | 1 | One-cycle pulse: frame statistics complete |
| red_sum | output | PIX_W+CNT_W | Sum of red values |
| red_sqsum | output | 2*PIX_W+CNT_W | Sum of squared red values |
| red_max | output | PIX_W | Largest red value |
| red_sqmax | output | 2*PIX_W | Largest squared red value |
| grn_sum | output | PIX_W+CNT_W | Sum of green values |
| grn_max | output | PIX_W | Largest green value |
| blu_sum | output | PIX_W+CNT_W | Sum of blue values |
| blu_sqsum | output | 2*PIX_W+CNT_W | Sum of squared blue values |
| blu_max | output | PIX_W | Largest blue value |
| blu_sqmax | output | 2*PIX_W | Largest squared blue value |

## Verification
The bench drives a frame that lights only red sites. A block that got the row or column parity wrong would pour that energy into green or blue. It also drives a valid pixel alongside `frame_start` and aborts a frame halfway. A block that let the early pixel in, or kept stale counts or position, would show inflated sums or shifted channels. It adds pixels after the frame end and idle cycles carrying full-scale data, which would raise sums or maxima in a block that did not gate them. An all-full-scale frame and random frames with gaps check the squaring path and `stats_done` timing. The done check catches a pulse that comes a cycle early, comes late, or is held high.

// File: rtl/bayer_stats.sv
module bayer_stats #(
  parameter int PIX_W = 8,
  parameter int COLS  = 320,
  parameter int ROWS  = 240
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          pix_valid,
  input  logic [PIX_W-1:0]              pix_data,
  output logic                          stats_done,
  output logic [PIX_W+$clog2(COLS*ROWS+1)-1:0]   red_sum,
  output logic [2*PIX_W+$clog2(COLS*ROWS+1)-1:0] red_sqsum,
  output logic [PIX_W-1:0]              red_max,
  output logic [2*PIX_W-1:0]            red_sqmax,
  output logic [PIX_W+$clog2(COLS*ROWS+1)-1:0]   grn_sum,
  output logic [PIX_W-1:0]              grn_max,
  output logic [PIX_W+$clog2(COLS*ROWS+1)-1:0]   blu_sum,
  output logic [2*PIX_W+$clog2(COLS*ROWS+1)-1:0] blu_sqsum,
  output logic [PIX_W-1:0]              blu_max,
  output logic [2*PIX_W-1:0]            blu_sqmax
);
  localparam int NPIX    = COLS * ROWS;
  localparam int CNT_W   = $clog2(NPIX + 1);
  localparam int SUM_W   = PIX_W + CNT_W;
  localparam int SQ_W    = 2 * PIX_W;
  localparam int SQSUM_W = SQ_W + CNT_W;
  localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             full;

  wire take     = pix_valid & ~full & ~frame_start;
  wire col_end  = (col == COL_W'(COLS - 1));
  wire row_end  = (row == ROW_W'(ROWS - 1));
  wire is_red   = ~row[0] & ~col[0];
  wire is_blu   = row[0] & col[0];
  wire is_grn   = row[0] ^ col[0];
  wire [SQ_W-1:0] sq = SQ_W'(pix_data) * SQ_W'(pix_data);

  assign red_sqmax = SQ_W'(red_max) * SQ_W'(red_max);
  assign blu_sqmax = SQ_W'(blu_max) * SQ_W'(blu_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0; row <= '0; full <= 1'b0; stats_done <= 1'b0;
      red_sum <= '0; red_sqsum <= '0; red_max <= '0;
      grn_sum <= '0; grn_max <= '0;
      blu_sum <= '0; blu_sqsum <= '0; blu_max <= '0;
    end else if (frame_start) begin
      col <= '0; row <= '0; full <= 1'b0; stats_done <= 1'b0;
      red_sum <= '0; red_sqsum <= '0; red_max <= '0;
      grn_sum <= '0; grn_max <= '0;
      blu_sum <= '0; blu_sqsum <= '0; blu_max <= '0;
    end else begin
      stats_done <= 1'b0;
      if (take) begin
        if (col_end) begin
          col <= '0;
          if (row_end) begin
            full       <= 1'b1;
            stats_done <= 1'b1;
          end else begin
            row <= row + ROW_W'(1);
          end
        end else begin
          col <= col + COL_W'(1);
        end
        if (is_red) begin
          red_sum   <= red_sum + SUM_W'(pix_data);
          red_sqsum <= red_sqsum + SQSUM_W'(sq);
          if (pix_data > red_max) red_max <= pix_data;
        end
        if (is_grn) begin
          grn_sum <= grn_sum + SUM_W'(pix_data);
          if (pix_data > grn_max) grn_max <= pix_data;
        end
        if (is_blu) begin
          blu_sum   <= blu_sum + SUM_W'(pix_data);
          blu_sqsum <= blu_sqsum + SQSUM_W'(sq);
          if (pix_data > blu_max) blu_max <= pix_data;
        end
      end
    end
  end
endmodule

// File: rtl/bayer_stats_chk.sv
module bayer_stats_chk #(
  parameter int PIX_W   = 8,
  parameter int SUM_W   = 25,
  parameter int SQSUM_W = 33
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               pix_valid,
  input logic               full,
  input logic               stats_done,
  input logic [SUM_W-1:0]   red_sum,
  input logic [SQSUM_W-1:0] red_sqsum,
  input logic [PIX_W-1:0]   red_max,
  input logic [SUM_W-1:0]   grn_sum,
  input logic [PIX_W-1:0]   grn_max,
  input logic [SUM_W-1:0]   blu_sum,
  input logic [SQSUM_W-1:0] blu_sqsum,
  input logic [PIX_W-1:0]   blu_max
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stats_done |=> !stats_done); // R7
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    stats_done |-> ($past(pix_valid) && !$past(frame_start))); // R7
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (red_sum == '0 && grn_sum == '0 && blu_sum == '0 &&
                     red_max == '0 && grn_max == '0 && blu_max == '0)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (red_sum >= $past(red_sum) && grn_sum >= $past(grn_sum) &&
                      blu_sum >= $past(blu_sum) && red_sqsum >= $past(red_sqsum) &&
                      blu_sqsum >= $past(blu_sqsum))); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !frame_start) |=> ($stable(red_sum) && $stable(grn_sum) && $stable(blu_sum) &&
                                $stable(red_max) && $stable(grn_max) && $stable(blu_max))); // R8
  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !frame_start) |=> ($stable(red_sum) && $stable(grn_sum) &&
                                      $stable(blu_sum) && $stable(red_sqsum))); // R9
  AST_SUM_GE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (red_sum >= SUM_W'(red_max)) && (blu_sum >= SUM_W'(blu_max)) &&
    (grn_sum >= SUM_W'(grn_max))); // R4
  AST_SQ_GE_LIN: assert property (@(posedge clk) disable iff (!rst_n)
    (red_sqsum >= SQSUM_W'(red_sum)) && (blu_sqsum >= SQSUM_W'(blu_sum))); // R3
endmodule

bind bayer_stats bayer_stats_chk #(.PIX_W(PIX_W), .SUM_W(SUM_W), .SQSUM_W(SQSUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
  .full(full), .stats_done(stats_done),
  .red_sum(red_sum), .red_sqsum(red_sqsum), .red_max(red_max),
  .grn_sum(grn_sum), .grn_max(grn_max),
  .blu_sum(blu_sum), .blu_sqsum(blu_sqsum), .blu_max(blu_max)
);

// File: tb/tb_bayer_stats.sv
`timescale 1ns/1ps
module tb_bayer_stats;
  localparam int PIX_W   = 8;
  localparam int COLS    = 8;
  localparam int ROWS    = 6;
  localparam int NPIX    = COLS * ROWS;
  localparam int CNT_W   = $clog2(NPIX + 1);
  localparam int SUM_W   = PIX_W + CNT_W;
  localparam int SQSUM_W = 2 * PIX_W + CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic pix_valid = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic stats_done;
  logic [SUM_W-1:0]   red_sum, grn_sum, blu_sum;
  logic [SQSUM_W-1:0] red_sqsum, blu_sqsum;
  logic [PIX_W-1:0]   red_max, grn_max, blu_max;
  logic [2*PIX_W-1:0] red_sqmax, blu_sqmax;

  always #2 clk = ~clk;

  bayer_stats #(.PIX_W(PIX_W), .COLS(COLS), .ROWS(ROWS)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_data(pix_data), .stats_done(stats_done),
    .red_sum(red_sum), .red_sqsum(red_sqsum), .red_max(red_max), .red_sqmax(red_sqmax),
    .grn_sum(grn_sum), .grn_max(grn_max),
    .blu_sum(blu_sum), .blu_sqsum(blu_sqsum), .blu_max(blu_max), .blu_sqmax(blu_sqmax)
  );

  int checks = 0;
  int errors = 0;
  longint e_sum[3], e_sq[3], e_max[3];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int chan_of(input int k);
    int r = k / COLS;
    int c = k % COLS;
    if (r % 2 == 0 && c % 2 == 0) return 0;
    if (r % 2 == 1 && c % 2 == 1) return 2;
    return 1;
  endfunction

  function automatic logic [PIX_W-1:0] pix_of(input int pat, input int k);
    case (pat)
      0: return '0;
      1: return '1;
      2: return PIX_W'((k * 5) % 256);
      4: return (chan_of(k) == 0) ? PIX_W'(255) : PIX_W'(0);
      default: return PIX_W'($urandom % 256);
    endcase
  endfunction

  task automatic clear_exp();
    for (int c = 0; c < 3; c++) begin e_sum[c] = 0; e_sq[c] = 0; e_max[c] = 0; end
  endtask

  task automatic check_all(input string tag);
    chk("R3", {tag, " red sum"}, longint'(red_sum), e_sum[0]);
    chk("R3", {tag, " red sqsum"}, longint'(red_sqsum), e_sq[0]);
    chk("R4", {tag, " red max"}, longint'(red_max), e_max[0]);
    chk("R4", {tag, " red sqmax"}, longint'(red_sqmax), e_max[0] * e_max[0]);
    chk("R5", {tag, " grn sum"}, longint'(grn_sum), e_sum[1]);
    chk("R5", {tag, " grn max"}, longint'(grn_max), e_max[1]);
    chk("R3", {tag, " blu sum"}, longint'(blu_sum), e_sum[2]);
    chk("R3", {tag, " blu sqsum"}, longint'(blu_sqsum), e_sq[2]);
    chk("R4", {tag, " blu max"}, longint'(blu_max), e_max[2]);
    chk("R4", {tag, " blu sqmax"}, longint'(blu_sqmax), e_max[2] * e_max[2]);
  endtask

  task automatic send_frame(input string tag, input int pat, input bit gaps, input bit fs_pix);
    frame_start = 1'b1;
    pix_valid = fs_pix;
    pix_data = PIX_W'(200);
    @(negedge clk);
    frame_start = 1'b0;
    pix_valid = 1'b0;
    clear_exp();
    for (int k = 0; k < NPIX; k++) begin
      logic [PIX_W-1:0] v;
      int ch;
      if (gaps) begin
        int n = $urandom % 3;
        for (int g = 0; g < n; g++) begin
          pix_valid = 1'b0;
          pix_data = '1;
          @(negedge clk);
          chk("R9", {tag, " done during idle"}, longint'(stats_done), 0);
        end
      end
      v = pix_of(pat, k);
      ch = chan_of(k);
      e_sum[ch] += v;
      if (ch != 1) e_sq[ch] += longint'(v) * longint'(v);
      if (v > e_max[ch]) e_max[ch] = v;
      pix_valid = 1'b1;
      pix_data = v;
      @(negedge clk);
      if (k < NPIX - 1)
        chk("R7", {tag, " early done"}, longint'(stats_done), 0);
    end
    pix_valid = 1'b0;
    chk("R7", {tag, " done after last pixel"}, longint'(stats_done), 1);
    check_all(tag);
    @(negedge clk);
    chk("R7", {tag, " done one cycle"}, longint'(stats_done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    clear_exp();
    check_all("R1 reset");
    chk("R1", "reset done", longint'(stats_done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    send_frame("zeros", 0, 1'b0, 1'b0);
    send_frame("R10 full scale", 1, 1'b0, 1'b0);
    send_frame("ramp", 2, 1'b0, 1'b0);
    send_frame("R2 red only", 4, 1'b0, 1'b0);
    chk("R2", "green empty", longint'(grn_sum), 0);
    chk("R2", "blue empty", longint'(blu_sum), 0);

    // R9: zeros frame with full-scale data on idle cycles
    send_frame("R9 idle data", 0, 1'b1, 1'b0);
    // R6: valid pixel with frame_start is dropped
    send_frame("R6 start pixel", 2, 1'b0, 1'b1);

    // R8: extra pixels after frame end
    for (int k = 0; k < 6; k++) begin
      pix_valid = 1'b1;
      pix_data = '1;
      @(negedge clk);
      chk("R8", "done on extra pixel", longint'(stats_done), 0);
    end
    pix_valid = 1'b0;
    check_all("R8 hold");

    // R6: abort partway with full-scale pixels, then a fresh frame
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int k = 0; k < 11; k++) begin
      pix_valid = 1'b1;
      pix_data = '1;
      @(negedge clk);
    end
    pix_valid = 1'b0;
    send_frame("R6 abort", 2, 1'b0, 1'b0);

    for (int f = 0; f < 6; f++)
      send_frame("random", 3, 1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule